// File: doc/BRIEF.md
# Adaptive Proportional Band Scaler

This block works out the proportional band for a primary controller that steers up to six secondary loops running in parallel. Each secondary has a gain factor, which sets its share of the primary's response, and a flag that is high while that secondary is in control. The block adds up every gain factor. It also adds up the gain factors of the secondaries that are in control. It divides the second sum by the first, raises the ratio to a configured minimum fraction if the ratio falls below it, and multiplies the result by the band that applies when every secondary is in control. The primary's tuning therefore follows the number of loops it is actually driving, and the minimum fraction keeps the gain from growing without limit.

All values are unsigned Q8.8, and the minimum fraction is unsigned Q0.16. The ratio comes from a sequential restoring divider that produces one quotient bit per cycle. A request is taken on a valid/ready handshake: `in_ready` is high only when the block is idle and holds no result that has not been collected. While `in_ready` is low, a request must stay on the pins with `in_valid` high. The result is offered on `out_valid`. It stays there, unchanged, until `out_ready` accepts it, so a slow consumer applies back-pressure all the way to the input. Outputs change only when a new result appears.

Top module: `adaptive_band_scaler`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and `band_out`, `frac_out` and `act_sum` are all 0.
- R2: `act_sum` equals the sum of the gain factors whose `in_ctl` bit is set. Slot i's gain is `gains[16*i+15:16*i]`, and its flag is `in_ctl[i]`.
- R3: The total sum adds all six gain factors whatever the flags say. A slot with a zero gain adds nothing, even when its flag is set.
- R4: The unclamped fraction is floor(active*65536/total), held as unsigned Q1.16 in 17 bits. The value 0x10000 means 1.0, which is the result when every slot with a nonzero gain is in control.
- R5: `frac_out` is the larger of the unclamped fraction and `min_frac`.
- R6: `band_out` equals floor(frac_out*band_full/65536), in Q8.8.
- R7: When the total sum is zero, no division is done. `frac_out` equals `min_frac`, and `out_valid` rises 1 cycle after the request is accepted.
- R8: When the total sum is nonzero, `out_valid` rises 17 cycles after the request is accepted.
- R9: Once a request has been accepted, `in_ready` stays low until the result is collected. Any `in_valid` stimulus during that time has no effect on the pending result.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all three outputs stay stable. `in_ready` returns high only in the cycle after the result is collected.
- R11: Between results, the three outputs keep their last values. They change only in the cycle in which `out_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle; a request can be taken |
| gains | input | 96 | Six Q8.8 gain factors; slot i at bits 16*i+15:16*i |
| in_ctl | input | 6 | In-control flag per slot |
| band_full | input | 16 | Band with every secondary in control, Q8.8 |
| min_frac | input | 16 | Lower bound on the fraction, Q0.16 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| band_out | output | 16 | Scaled band, Q8.8 |
| frac_out | output | 17 | Clamped fraction, Q1.16 |
| act_sum | output | 19 | Sum of the in-control gain factors, Q11.8 |

## Verification
Some rules can be checked in every cycle, and the assertions cover them. These are the handshake rules: `in_ready` stays low while busy or holding a result, a stalled result does not move, and `in_ready` returns only after the result is taken. They also cover the bounds on the values (the fraction never exceeds 1.0, and the band never exceeds the full-run band) and the fact that outputs change only when a result appears. The exact values of the sums, the quotient, the clamp and the product, together with the 17-cycle and 1-cycle latencies, depend on the request. Only the bench's scenarios show those. They include the following cases: every slot in control, a single slot in control, the clamp taking over, flags set on empty slots, weights that differ from slot to slot, a zero total, a request attempted while busy, and a stalled consumer.

// File: rtl/abs_pkg.sv
package abs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2,
    ST_HOLD = 2'd3
  } abs_state_e;
endpackage

// File: rtl/abs_gain_sum.sv
// Adds the gain factors of the slots whose select bit is set.
module abs_gain_sum #(
  parameter int N_SLOT = 6,
  parameter int VAL_W  = 16,
  parameter int SUM_W  = 19
) (
  input  logic [N_SLOT*VAL_W-1:0] gains,
  input  logic [N_SLOT-1:0]       sel,
  output logic [SUM_W-1:0]        sum
);
  logic [SUM_W-1:0] term [N_SLOT];
  logic [SUM_W-1:0] acc;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_term
    assign term[i] = sel[i] ? SUM_W'(gains[i*VAL_W +: VAL_W]) : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_SLOT; i++) acc = acc + term[i];
  end

  assign sum = acc;
endmodule

// File: rtl/abs_frac_divider.sv
// Restoring divider for a ratio of at most 1.0.
// The integer bit is settled on load, then one fraction bit is produced per cycle.
module abs_frac_divider #(
  parameter int SUM_W  = 19,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SUM_W-1:0]  num,
  input  logic [SUM_W-1:0]  den,
  output logic [FRAC_W:0]   quot,
  output logic              fin
);
  localparam int CNT_W = $clog2(FRAC_W + 1);

  logic [SUM_W-1:0]  rem_q, den_q;
  logic              int_q, busy_q;
  logic [FRAC_W-1:0] fsr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SUM_W:0]    shifted, diff;
  logic              ge;
  logic              unused_top;

  assign shifted    = {rem_q, 1'b0};
  assign ge         = shifted >= {1'b0, den_q};
  assign diff       = shifted - {1'b0, den_q};
  assign unused_top = diff[SUM_W] ^ shifted[SUM_W];
  assign fin        = busy_q && (cnt_q == CNT_W'(FRAC_W - 1));
  assign quot       = {int_q, fsr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      int_q  <= 1'b0;
      busy_q <= 1'b0;
      fsr_q  <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      den_q  <= den;
      int_q  <= num >= den;
      rem_q  <= (num >= den) ? num - den : num;
      fsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q <= ge ? diff[SUM_W-1:0] : shifted[SUM_W-1:0];
      fsr_q <= {fsr_q[FRAC_W-2:0], ge};
      cnt_q <= cnt_q + 1'b1;
      if (fin) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/abs_band_scale.sv
// Applies the lower bound to the fraction and scales the full-run band by it.
module abs_band_scale #(
  parameter int VAL_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic [FRAC_W:0]   raw,
  input  logic [FRAC_W-1:0] floor_frac,
  input  logic              use_floor,
  input  logic [VAL_W-1:0]  band,
  output logic [FRAC_W:0]   frac,
  output logic [VAL_W-1:0]  band_o
);
  localparam int PROD_W = FRAC_W + VAL_W + 1;

  logic [FRAC_W:0]   floor_ext;
  logic [PROD_W-1:0] prod;
  logic              unused_bits;

  assign floor_ext   = {1'b0, floor_frac};
  assign frac        = (use_floor || (raw < floor_ext)) ? floor_ext : raw;
  assign prod        = PROD_W'(frac) * PROD_W'(band);
  assign band_o      = prod[FRAC_W +: VAL_W];
  assign unused_bits = ^{prod[PROD_W-1], prod[FRAC_W-1:0]};
endmodule

// File: rtl/adaptive_band_scaler.sv
module adaptive_band_scaler #(
  parameter int N_SLOT = 6,
  parameter int VAL_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N_SLOT*VAL_W-1:0] gains,
  input  logic [N_SLOT-1:0]       in_ctl,
  input  logic [VAL_W-1:0]        band_full,
  input  logic [FRAC_W-1:0]       min_frac,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [VAL_W-1:0]        band_out,
  output logic [FRAC_W:0]         frac_out,
  output logic [VAL_W+$clog2(N_SLOT)-1:0] act_sum
);
  import abs_pkg::*;

  localparam int SUM_W = VAL_W + $clog2(N_SLOT);

  abs_state_e        state_q;
  logic              accept;
  logic [SUM_W-1:0]  tot_c, act_c;
  logic [SUM_W-1:0]  act_q;
  logic [VAL_W-1:0]  band_q;
  logic [FRAC_W-1:0] min_q;
  logic              zero_q;
  logic [FRAC_W:0]   quot;
  logic              div_fin;
  logic [FRAC_W:0]   frac_c;
  logic [VAL_W-1:0]  band_c;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  abs_gain_sum #(.N_SLOT(N_SLOT), .VAL_W(VAL_W), .SUM_W(SUM_W)) u_total (
    .gains(gains), .sel({N_SLOT{1'b1}}), .sum(tot_c)
  );

  abs_gain_sum #(.N_SLOT(N_SLOT), .VAL_W(VAL_W), .SUM_W(SUM_W)) u_active (
    .gains(gains), .sel(in_ctl), .sum(act_c)
  );

  abs_frac_divider #(.SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .load(accept && (tot_c != '0)),
    .num(act_c), .den(tot_c),
    .quot(quot), .fin(div_fin)
  );

  abs_band_scale #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_scale (
    .raw(quot), .floor_frac(min_q), .use_floor(zero_q), .band(band_q),
    .frac(frac_c), .band_o(band_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      act_q     <= '0;
      band_q    <= '0;
      min_q     <= '0;
      zero_q    <= 1'b0;
      out_valid <= 1'b0;
      band_out  <= '0;
      frac_out  <= '0;
      act_sum   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          act_q   <= act_c;
          band_q  <= band_full;
          min_q   <= min_frac;
          zero_q  <= (tot_c == '0);
          state_q <= (tot_c == '0) ? ST_FIN : ST_DIV;
        end
        ST_DIV: if (div_fin) state_q <= ST_FIN;
        ST_FIN: begin
          band_out  <= band_c;
          frac_out  <= frac_c;
          act_sum   <= act_q;
          out_valid <= 1'b1;
          state_q   <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abs_checker.sv
module abs_checker #(
  parameter int VAL_W  = 16,
  parameter int FRAC_W = 16,
  parameter int SUM_W  = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VAL_W-1:0]  band_out,
  input logic [FRAC_W:0]   frac_out,
  input logic [SUM_W-1:0]  act_sum,
  input logic [VAL_W-1:0]  band_q
);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_no_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(band_out) && $stable(frac_out) && $stable(act_sum)));

  a_r10_ready_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(out_valid && out_ready));

  a_r11_change_only_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(out_valid) |-> ($stable(band_out) && $stable(frac_out) && $stable(act_sum)));

  a_r5_frac_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (frac_out <= (FRAC_W+1)'(1 << FRAC_W)));

  a_r6_band_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (band_out <= band_q));
endmodule

bind adaptive_band_scaler abs_checker #(.VAL_W(VAL_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .band_out(band_out),
  .frac_out(frac_out), .act_sum(act_sum), .band_q(band_q)
);

// File: tb/adaptive_band_scaler_tb_top.sv
`timescale 1ns/1ps
module adaptive_band_scaler_tb_top;
  localparam int N = 6, VW = 16, FW = 16, SW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*VW-1:0] gains = '0;
  logic [N-1:0] in_ctl = '0;
  logic [VW-1:0] band_full = '0;
  logic [FW-1:0] min_frac = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [VW-1:0] band_out;
  logic [FW:0] frac_out;
  logic [SW-1:0] act_sum;

  int checks = 0, errors = 0;
  longint cyc = 0;

  typedef struct {
    longint act, frac, band;
    longint lat, acc;
    int     stall;
  } item_t;
  item_t sb[$];

  adaptive_band_scaler dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .gains(gains), .in_ctl(in_ctl), .band_full(band_full), .min_frac(min_frac),
    .out_valid(out_valid), .out_ready(out_ready), .band_out(band_out),
    .frac_out(frac_out), .act_sum(act_sum)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: computes the expected result, waits for the block to be idle, then issues the request.
  task automatic send(input logic [N*VW-1:0] g, input logic [N-1:0] f,
                      input logic [VW-1:0] b, input logic [FW-1:0] m,
                      input int stall, input bit poke);
    item_t it;
    longint tot = 0, act = 0, raw;
    for (int i = 0; i < N; i++) begin
      tot += g[i*VW +: VW];
      if (f[i]) act += g[i*VW +: VW];
    end
    raw = (tot == 0) ? 0 : (act << FW) / tot;
    it.act   = act;
    it.frac  = (tot == 0) ? m : ((raw > m) ? raw : m);
    it.band  = (it.frac * b) >> FW;
    it.lat   = (tot == 0) ? 1 : FW + 1;
    it.stall = stall;
    while (!in_ready) @(negedge clk);
    gains = g; in_ctl = f; band_full = b; min_frac = m; in_valid = 1'b1;
    it.acc = cyc + 1;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      for (int k = 0; k < 5; k++) begin
        gains = ~g; in_ctl = ~f; band_full = ~b; min_frac = 16'h0100; in_valid = 1'b1;
        chk("R9 in_ready while busy", in_ready, 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the expected item when a result appears and compares it.
  item_t cur;
  bit ov_prev = 1'b0;
  int stall_cnt = 0;
  longint h_band, h_frac, h_act;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !ov_prev) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected result actual=1 expected=0");
        end else begin
          cur = sb.pop_front();
          chk("R2 act_sum", act_sum, cur.act);
          chk("R4/R5 frac_out", frac_out, cur.frac);
          chk("R6 band_out", band_out, cur.band);
          chk("R7/R8 latency", cyc - cur.acc, cur.lat);
          stall_cnt = cur.stall;
        end
        h_band = band_out; h_frac = frac_out; h_act = act_sum;
      end else if (out_valid) begin
        chk("R10 stable band", band_out, h_band);
        chk("R10 stable frac", frac_out, h_frac);
      end else if (ov_prev) begin
        chk("R10 in_ready after take", in_ready, 1);
        chk("R11 hold band", band_out, h_band);
        chk("R11 hold act", act_sum, h_act);
      end
      if (out_valid && stall_cnt > 0) begin
        out_ready = 1'b0;
        stall_cnt--;
      end else out_ready = 1'b1;
      ov_prev = out_valid;
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 band_out", band_out, 0);
    chk("R1 frac_out", frac_out, 0);
    chk("R1 act_sum", act_sum, 0);
    // R4: every slot in control gives 1.0
    send({6{16'h0100}}, 6'h3f, 16'h3200, 16'h4ccd, 0, 0);
    // R3: unused slots are zero, one of three in control
    send({48'h0, {3{16'h0100}}}, 6'b000001, 16'h3200, 16'h4ccd, 0, 0);
    // R5: clamp takes over with one of six
    send({6{16'h0100}}, 6'b000100, 16'h3200, 16'h4ccd, 0, 0);
    // R3: flags set only on empty slots
    send({32'h0, {4{16'h0200}}}, 6'b110000, 16'h6400, 16'h2000, 0, 0);
    // R2: weighted gains
    send({16'h0, 16'h0000, 16'h0180, 16'h0080, 16'h0100, 16'h0200}, 6'b001001, 16'h1234, 16'h1000, 0, 0);
    send({16'h7fff, 16'h0001, 16'hffff, 16'h0333, 16'h00ff, 16'h8000}, 6'b101010, 16'hffff, 16'h0000, 0, 0);
    // R7: zero total
    send('0, 6'h3f, 16'h5000, 16'h8000, 0, 0);
    // R9: stimulus while busy is ignored
    send({6{16'h0040}}, 6'b011011, 16'h2000, 16'h1111, 0, 1);
    // R10: stalled consumer
    send({16'h0, 16'h0300, 16'h0, 16'h0100, 16'h0, 16'h0100}, 6'b000101, 16'h0a00, 16'h0100, 6, 0);
    send('0, 6'h00, 16'hffff, 16'hffff, 3, 0);
    send({6{16'hffff}}, 6'b111110, 16'hffff, 16'hf000, 0, 0);
    wait (sb.size() == 0 && !out_valid && in_ready);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule